// File: doc/BRIEF.md
# Word-Rate Clock Divider with Quarter-Period Phase Shift

This block derives the slower clocks of a 16-to-1 serializer from the full-rate clock. It uses a chain of divide-by-2 toggle stages. Stage 0 toggles on every full-rate edge. Each later stage changes state whenever the stage before it rises. All stages are held in the full-rate clock domain, so every divided clock has a fixed, known edge position relative to the full-rate clock. The half, quarter, eighth and sixteenth rate clocks are all exported to the serializer tree.

A second output, the word clock, is a copy of the sixteenth-rate clock. It can be delayed by 0, 4, 8 or 12 full-rate cycles, which is a phase shift in quarter-period steps. The shift is chosen by a two-bit static select. The select is sampled only at a rising edge of the unshifted sixteenth-rate clock. Between those edges, a change on the select waits. The internal sixteenth-rate clock itself is never shifted.

Top module: `clk_word_divider`

## Requirements
- R1: While `rst_n` is low, every bit of `div_clk` and `word_clk` is 0, and the held phase setting is the 270° code 2'b00.
- R2: After reset release, let n be the number of full-rate rising edges since release. After edge n, `div_clk[0]` (half rate) equals n mod 2.
- R3: `div_clk[1]` (quarter rate) toggles only at edges where `div_clk[0]` rises. After edge n it equals bit 1 of (n+1).
- R4: `div_clk[2]` (eighth rate) toggles only where `div_clk[1]` rises. After edge n it equals bit 2 of (n+3).
- R5: `div_clk[3]` (sixteenth rate, called C16 here) toggles only where `div_clk[2]` rises. After edge n it equals bit 3 of (n+7). It has a 16-cycle period and is high for 8 cycles.
- R6: `word_clk` after edge n equals C16 after edge n−D, taken as 0 when n−D < 0. D is set by the held phase code: 2'b11 (0°) gives D=0, 2'b10 (90°) gives D=4, 2'b01 (180°) gives D=8, and 2'b00 (270°) gives D=12.
- R7: `phase_sel` is taken into the held phase code only at an edge where C16 rises, that is, at n mod 16 = 1. That edge's `word_clk` already uses the new code. A change at any other time has no effect until the next such edge.
- R8: The held phase code leaves reset as 2'b00, so `word_clk` trails C16 by 12 cycles until a different code is taken in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_full | input | 1 | Full-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_sel | input | 2 | Word clock phase code (11=0°, 10=90°, 01=180°, 00=270°) |
| div_clk | output | N_STAGES | Divided clocks, bit k = rate/2^(k+1) |
| word_clk | output | 1 | Phase-shifted sixteenth-rate word clock |

## Verification
A wrong divider stage bit changes the edge alignment of its own clock and of every slower stage. That mismatch shows on `div_clk` at the very next full-rate edge, and the slower stages show it within one of their own periods. A wrong delay-line bit or a wrong tap choice shows on `word_clk` as a shifted or broken edge within one 16-cycle word period. A held phase code taken in at the wrong time makes `word_clk` follow the wrong delay from that edge until the next C16 rising edge. For that reason the bench moves `phase_sel` in the middle of word periods and compares `word_clk` on every cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Quarter-period phase codes for the word clock.
    typedef enum logic [1:0] {
        PH_270 = 2'b00,
        PH_180 = 2'b01,
        PH_090 = 2'b10,
        PH_000 = 2'b11
    } phase_e;

    // Number of quarter periods of delay for a phase code.
    function automatic logic [1:0] quarter_steps(input phase_e ph);
        logic [1:0] steps;
        case (ph)
            PH_000:  steps = 2'd0;
            PH_090:  steps = 2'd1;
            PH_180:  steps = 2'd2;
            default: steps = 2'd3;
        endcase
        return steps;
    endfunction

endpackage

// File: rtl/clkdiv_chain.sv
module clkdiv_chain #(
    parameter int N_STAGES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [N_STAGES-1:0] div_q,
    output logic                last_next,
    output logic                last_rise
);

    typedef struct packed {
        logic [N_STAGES-1:0] div;
    } chain_t;

    chain_t q, d;

    always_comb begin
        d = q;
        d.div[0] = ~q.div[0];
        for (int k = 1; k < N_STAGES; k++) begin
            // A stage toggles when the stage before it rises.
            if (!q.div[k-1] && d.div[k-1]) begin
                d.div[k] = ~q.div[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign div_q     = q.div;
    assign last_next = d.div[N_STAGES-1];
    assign last_rise = !q.div[N_STAGES-1] && d.div[N_STAGES-1];

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (q.div == '0)); // R1

    AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q.div[0] != $past(q.div[0]))); // R2

    for (genvar k = 1; k < N_STAGES; k++) begin : g_ripple
        AST_RIPPLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (q.div[k] != $past(q.div[k])) |-> $rose(q.div[k-1])); // R3
    end

endmodule

// File: rtl/phase_tap.sv
module phase_tap
    import clkdiv_pkg::*;
#(
    parameter int PERIOD = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_next,
    input  logic       src_rise,
    input  logic [1:0] sel_in,
    output logic       out
);

    localparam int STEP  = PERIOD / 4;
    localparam int DEPTH = 3 * STEP;
    localparam int IDXW  = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0] hist;
        phase_e           sel;
        logic             out;
    } tap_t;

    tap_t q, d;
    logic [DEPTH:0]    taps;
    logic [IDXW-1:0]   idx;

    always_comb begin
        d = q;
        // taps[j] is the source value j cycles before the next one.
        taps[0] = src_next;
        for (int j = 1; j <= DEPTH; j++) begin
            taps[j] = q.hist[j-1];
        end
        d.hist = taps[DEPTH-1:0];
        if (src_rise) begin
            d.sel = phase_e'(sel_in);
        end
        case (quarter_steps(d.sel))
            2'd0:    idx = '0;
            2'd1:    idx = IDXW'(STEP);
            2'd2:    idx = IDXW'(2 * STEP);
            default: idx = IDXW'(3 * STEP);
        endcase
        d.out = taps[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.hist <= '0;
            q.sel  <= PH_270;
            q.out  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign out = q.out;

    AST_RESET_PHASE: assert property (@(posedge clk) !rst_n |-> (q.sel == PH_270 && !q.out)); // R1

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !src_rise |=> $stable(q.sel)); // R7

    AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sel == PH_000) |-> (q.out == q.hist[0])); // R6

    AST_HALF_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sel == PH_180) |-> (q.out != q.hist[0])); // R6

endmodule

// File: rtl/clk_word_divider.sv
module clk_word_divider #(
    parameter int N_STAGES = 4
) (
    input  logic                clk_full,
    input  logic                rst_n,
    input  logic [1:0]          phase_sel,
    output logic [N_STAGES-1:0] div_clk,
    output logic                word_clk
);

    localparam int WORD_PERIOD = 2 ** N_STAGES;

    logic last_next;
    logic last_rise;

    clkdiv_chain #(
        .N_STAGES(N_STAGES)
    ) u_chain (
        .clk       (clk_full),
        .rst_n     (rst_n),
        .div_q     (div_clk),
        .last_next (last_next),
        .last_rise (last_rise)
    );

    phase_tap #(
        .PERIOD(WORD_PERIOD)
    ) u_tap (
        .clk      (clk_full),
        .rst_n    (rst_n),
        .src_next (last_next),
        .src_rise (last_rise),
        .sel_in   (phase_sel),
        .out      (word_clk)
    );

endmodule

// File: tb/clk_word_divider_test.sv
module clk_word_divider_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] phase_sel = 2'b00;
    logic [3:0] div_clk;
    logic       word_clk;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  n_edges  = 0;
    bit  running  = 0;
    bit  finished = 0;
    logic [1:0] eff_sel = 2'b00;

    typedef struct {
        logic [3:0] div;
        logic       word;
        logic [1:0] eff;
        bit         pending;
        int         n;
    } exp_t;

    exp_t exp_q[$];

    clk_word_divider uut (
        .clk_full  (clk),
        .rst_n     (rst_n),
        .phase_sel (phase_sel),
        .div_clk   (div_clk),
        .word_clk  (word_clk)
    );

    always #2.5 clk = ~clk;

    function automatic logic stage_at(int m, int k);
        if (m <= 0) return 1'b0;
        return 1'(((m + (1 << k) - 1) >> k) & 1);
    endfunction

    task automatic check(string tag, logic act, logic expv, int n);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s edge %0d: actual %b expected %b", tag, n, act, expv);
        end
    endtask

    // Driver side of the scoreboard: one expected item per full-rate edge.
    always @(posedge clk) begin
        if (running) begin
            exp_t e;
            int   dly;
            n_edges++;
            if (n_edges % 16 == 1) eff_sel = phase_sel;
            dly = (3 - int'(eff_sel)) * 4;
            for (int k = 0; k < 4; k++) e.div[k] = stage_at(n_edges, k);
            e.word    = stage_at(n_edges - dly, 3);
            e.eff     = eff_sel;
            e.pending = (phase_sel != eff_sel);
            e.n       = n_edges;
            exp_q.push_back(e);
        end
    end

    // Monitor side: compare away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check("R2", div_clk[0], e.div[0], e.n);
            check("R3", div_clk[1], e.div[1], e.n);
            check("R4", div_clk[2], e.div[2], e.n);
            check("R5", div_clk[3], e.div[3], e.n);
            if (e.pending)          check("R7", word_clk, e.word, e.n);
            else if (e.eff == 2'b00) check("R8", word_clk, e.word, e.n);
            else                    check("R6", word_clk, e.word, e.n);
        end
    end

    task automatic wait_cycles(int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic set_phase(logic [1:0] v);
        @(negedge clk);
        phase_sel = v;
    endtask

    initial begin
        // R1: reset state
        wait_cycles(4);
        check("R1", div_clk[0], 1'b0, 0);
        check("R1", div_clk[1], 1'b0, 0);
        check("R1", div_clk[2], 1'b0, 0);
        check("R1", div_clk[3], 1'b0, 0);
        check("R1", word_clk, 1'b0, 0);
        rst_n   = 1'b1;
        running = 1'b1;
        // R8: default 270° for a while
        wait_cycles(40);
        // R6: each code, changed in the middle of a word period
        set_phase(2'b11); wait_cycles(45);
        set_phase(2'b10); wait_cycles(51);
        set_phase(2'b01); wait_cycles(37);
        set_phase(2'b00); wait_cycles(48);
        // R7: several changes inside one period, only the last one counts
        set_phase(2'b11); wait_cycles(3);
        set_phase(2'b01); wait_cycles(2);
        set_phase(2'b10); wait_cycles(60);
        set_phase(2'b11); wait_cycles(7);
        set_phase(2'b00); wait_cycles(40);
        running = 1'b0;
        wait_cycles(3);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule